// File: doc/BRIEF.md
# Four-Plane Write-Mode-0 Memory Datapath

This block is the write path of a planar graphics memory. The memory has four byte-wide planes that share one address. A CPU read returns the byte from every plane at that address. The same read also captures those four bytes in a set of holding latches.

A CPU write sends one byte through a fixed chain of stages:

1. The byte is rotated right by a programmable count.
2. For each plane, a set/reset stage may replace the rotated byte with a constant of all zeros or all ones.
3. A bit mask chooses, bit by bit, between this processed byte and the latched byte.
4. A per-plane enable decides which planes accept the result.

Configuration registers are written through a separate index/data port. The latch merge lets software stencil a foreground over a background without reading memory first. The set/reset stage lets one write set all four planes to a chosen colour, whatever they held before.

Top module: `planar_wr_path`

## Requirements
- R1: A CPU read (`cpu_req`=1, `cpu_we`=0) loads the four latches from the addressed location. `cpu_rvalid` is 1 in the cycle after the request edge. In that cycle `cpu_rdata[8n+7:8n]` holds the byte of plane n.
- R2: On a write, every bit position whose bit-mask bit is 0 takes its value from the latch byte of that plane, not from the memory contents at the target address.
- R3: The CPU byte is rotated right by the 3-bit rotate count before the set/reset stage.
- R4: When the set/reset enable bit n is 1, plane n receives FFh if set/reset value bit n is 1, or 00h if it is 0, in place of the rotated CPU byte.
- R5: Map-mask bit n enables writes to plane n. A plane whose bit is 0 is left unchanged. For example, map mask 09h writes planes 0 and 3 only.
- R6: After reset, the following hold:
  - the bit mask is FFh;
  - set/reset value, set/reset enable, rotate count and map mask are 0;
  - every memory byte and every latch is 0;
  - `cpu_rvalid` is 0.
- R7: A register write with `reg_we`=1 stores `reg_wdata` in the register chosen by `reg_idx`. The indices are: 0 set/reset value, 1 set/reset enable, 2 rotate count, 3 bit mask, 4 map mask. The new value applies to the next CPU write.
- R8: Plane 0 is blue, plane 1 green and plane 3 intensity.
  - Writing FFh with map mask 01h over green data gives cyan (planes 0 and 1 both FFh).
  - With set/reset enabled on all planes, map mask 0Fh and value 01h, the same location becomes pure blue (plane 0 FFh, others 00h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write value |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Location address, shared by all planes |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Latched bytes of all four planes, plane n at bits 8n+7:8n |

## Verification
Both a register write and a CPU write land on the rising edge at which they are presented. The effect of a write therefore becomes visible through a later read. The read result and `cpu_rvalid` appear one edge after the read request.

The driver presents every stimulus at a falling edge and holds it for exactly one rising edge. Each read pushes its expected four-plane word into a queue. The monitor compares against that queue at the falling edge after `cpu_rvalid` rises, so every result is sampled half a cycle after the edge that produced it.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      IDX_SR_VAL  = 3'd0,
      IDX_SR_EN   = 3'd1,
      IDX_ROT     = 3'd2,
      IDX_BITMASK = 3'd3,
      IDX_MAPMASK = 3'd4
   } reg_idx_e;

   typedef enum int {
      ROT_DOUBLED = 0,
      ROT_LOGSTAGE = 1
   } rot_impl_e;
endpackage

// File: rtl/pwp_regs.sv
module pwp_regs
   import pwp_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int DW     = 8,
   parameter int RW     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_idx,
   input  logic [DW-1:0]        reg_wdata,
   output logic [PLANES-1:0]    sr_val_o,
   output logic [PLANES-1:0]    sr_en_o,
   output logic [RW-1:0]        rot_o,
   output logic [DW-1:0]        bit_mask_o,
   output logic [PLANES-1:0]    map_mask_o
);
   generate
      if (PLANES > DW) begin : g_bad_planes
         $error("pwp_regs: PLANES must not exceed DW");
      end
      if (RW > DW) begin : g_bad_rw
         $error("pwp_regs: RW must not exceed DW");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_val_o   <= '0;
         sr_en_o    <= '0;
         rot_o      <= '0;
         bit_mask_o <= '1;
         map_mask_o <= '0;
      end else if (reg_we) begin
         case (reg_idx_e'(reg_idx))
            IDX_SR_VAL:  sr_val_o   <= reg_wdata[PLANES-1:0];
            IDX_SR_EN:   sr_en_o    <= reg_wdata[PLANES-1:0];
            IDX_ROT:     rot_o      <= reg_wdata[RW-1:0];
            IDX_BITMASK: bit_mask_o <= reg_wdata;
            IDX_MAPMASK: map_mask_o <= reg_wdata[PLANES-1:0];
            default: ;
         endcase
      end
   end

   AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_idx == IDX_BITMASK) |=> bit_mask_o == $past(reg_wdata)); // R7
   AST_MAP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_idx == IDX_MAPMASK) |=> map_mask_o == $past(reg_wdata[PLANES-1:0])); // R7
endmodule

// File: rtl/pwp_rotate.sv
module pwp_rotate
   import pwp_pkg::*;
#(
   parameter int DW   = 8,
   parameter int RW   = 3,
   parameter int IMPL = ROT_LOGSTAGE
) (
   input  logic [DW-1:0] din,
   input  logic [RW-1:0] amt,
   output logic [DW-1:0] dout
);
   generate
      if ((1 << RW) != DW) begin : g_bad_width
         $error("pwp_rotate: DW must equal 2**RW");
      end

      if (IMPL == ROT_DOUBLED) begin : g_doubled
         logic [2*DW-1:0] dbl;
         assign dbl  = {din, din} >> amt;
         assign dout = dbl[DW-1:0];
      end else begin : g_logstage
         logic [DW-1:0] stage [RW+1];
         assign stage[0] = din;
         for (genvar s = 0; s < RW; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stage[s+1] = amt[s]
               ? {stage[s][SH-1:0], stage[s][DW-1:SH]}
               : stage[s];
         end
         assign dout = stage[RW];
      end
   endgenerate

   always_comb begin
      if (amt == '0) begin
         AST_ROT_IDENT: assert (dout == din); // R3
      end
      AST_ROT_KEEPS_ONES: assert ($countones(dout) == $countones(din)); // R3
   end
endmodule

// File: rtl/pwp_plane_lane.sv
module pwp_plane_lane #(
   parameter int DW     = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     rot_data_i,
   input  logic              sr_en_i,
   input  logic              sr_val_i,
   input  logic [DW-1:0]     bit_mask_i,
   input  logic              plane_en_i,
   output logic [DW-1:0]     latch_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] mem_q [DEPTH];
   logic [DW-1:0] latch_q;
   logic [DW-1:0] sr_data;
   logic [DW-1:0] merged;

   assign sr_data = sr_en_i ? {DW{sr_val_i}} : rot_data_i;
   assign merged  = (sr_data & bit_mask_i) | (latch_q & ~bit_mask_i);
   assign latch_o = latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         latch_q <= '0;
      end else begin
         if (wr_i && plane_en_i) mem_q[addr_i] <= merged;
         if (rd_i) latch_q <= mem_q[addr_i];
      end
   end

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> latch_q == $past(mem_q[addr_i])); // R1
   AST_MASK_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && plane_en_i) |=>
         ((mem_q[$past(addr_i)] ^ $past(latch_q)) & ~$past(bit_mask_i)) == '0); // R2
   AST_SR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && plane_en_i && sr_en_i) |=>
         (mem_q[$past(addr_i)] & $past(bit_mask_i)) ==
         ({DW{$past(sr_val_i)}} & $past(bit_mask_i))); // R4
   AST_DISABLED_PLANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !plane_en_i) |=> mem_q[$past(addr_i)] == $past(mem_q[addr_i])); // R5
endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path
   import pwp_pkg::*;
#(
   parameter int PLANES   = 4,
   parameter int DW       = 8,
   parameter int ADDR_W   = 4,
   parameter int ROT_IMPL = ROT_LOGSTAGE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [2:0]           reg_idx,
   input  logic [DW-1:0]        reg_wdata,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DW-1:0]        cpu_wdata,
   output logic                 cpu_rvalid,
   output logic [PLANES*DW-1:0] cpu_rdata
);
   localparam int RW = $clog2(DW);

   generate
      if (PLANES < 1 || PLANES > DW) begin : g_bad_planes
         $error("planar_wr_path: PLANES out of range");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("planar_wr_path: ADDR_W out of range");
      end
   endgenerate

   logic [PLANES-1:0] sr_val, sr_en, map_mask;
   logic [RW-1:0]     rot_amt;
   logic [DW-1:0]     bit_mask;
   logic [DW-1:0]     rot_data;
   logic              wr, rd;

   assign wr = cpu_req && cpu_we;
   assign rd = cpu_req && !cpu_we;

   pwp_regs #(.PLANES(PLANES), .DW(DW), .RW(RW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_idx    (reg_idx),
      .reg_wdata  (reg_wdata),
      .sr_val_o   (sr_val),
      .sr_en_o    (sr_en),
      .rot_o      (rot_amt),
      .bit_mask_o (bit_mask),
      .map_mask_o (map_mask)
   );

   pwp_rotate #(.DW(DW), .RW(RW), .IMPL(ROT_IMPL)) u_rot (
      .din  (cpu_wdata),
      .amt  (rot_amt),
      .dout (rot_data)
   );

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_plane
         pwp_plane_lane #(.DW(DW), .ADDR_W(ADDR_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (wr),
            .rd_i       (rd),
            .addr_i     (cpu_addr),
            .rot_data_i (rot_data),
            .sr_en_i    (sr_en[p]),
            .sr_val_i   (sr_val[p]),
            .bit_mask_i (bit_mask),
            .plane_en_i (map_mask[p]),
            .latch_o    (cpu_rdata[p*DW +: DW])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cpu_rvalid <= 1'b0;
      else        cpu_rvalid <= rd;
   end

   AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> $past(rd)); // R1
   AST_READ_GIVES_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> cpu_rvalid); // R1
endmodule

// File: tb/planar_wr_path_tb.sv
module planar_wr_path_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [3:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rvalid;
   logic [31:0] cpu_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   planar_wr_path u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] idx, input logic [7:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_read(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(req);
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   // Monitor: read result is due on the falling edge after the rising edge
   // that took the request.
   always @(negedge clk) begin
      if (rst_n && cpu_rvalid) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected rvalid", 32'd1, 32'd0);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, cpu_rdata, e);
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 rvalid after reset", {31'd0, cpu_rvalid}, 32'd0);
      check("R6 latches after reset", cpu_rdata, 32'h0);

      cpu_read(4'd0, 32'h0000_0000, "R6 memory clear");
      cpu_write(4'd0, 8'hFF);
      cpu_read(4'd0, 32'h0000_0000, "R6 map mask resets to 0 so R5 blocks write");

      reg_wr(3'd4, 8'h0F);
      cpu_write(4'd1, 8'h5A);
      cpu_read(4'd1, 32'h5A5A_5A5A, "R1 all planes, R6 mask FF");

      reg_wr(3'd2, 8'h03);
      cpu_write(4'd2, 8'h81);
      cpu_read(4'd2, 32'h3030_3030, "R3 rotate right 3");
      reg_wr(3'd2, 8'h01);
      cpu_write(4'd2, 8'h03);
      cpu_read(4'd2, 32'h8181_8181, "R3 rotate right 1 wraps");
      reg_wr(3'd2, 8'h00);

      reg_wr(3'd4, 8'h09);
      cpu_write(4'd1, 8'hFF);
      cpu_read(4'd1, 32'hFF5A_5AFF, "R5 map mask 09h");

      reg_wr(3'd4, 8'h0F);
      reg_wr(3'd0, 8'h01);
      reg_wr(3'd1, 8'h05);
      cpu_write(4'd3, 8'h3C);
      cpu_read(4'd3, 32'h3C00_3CFF, "R4 set/reset on planes 0 and 2");
      reg_wr(3'd1, 8'h00);

      cpu_read(4'd1, 32'hFF5A_5AFF, "R1 latch load");
      reg_wr(3'd3, 8'h0F);
      cpu_write(4'd4, 8'h00);
      cpu_read(4'd4, 32'hF050_50F0, "R2 masked bits from latch");
      reg_wr(3'd3, 8'hFF);

      reg_wr(3'd4, 8'h00);
      cpu_write(4'd5, 8'h77);
      cpu_read(4'd5, 32'h0000_0000, "R7 map mask applies to next write");
      reg_wr(3'd4, 8'h0F);
      cpu_write(4'd5, 8'h77);
      cpu_read(4'd5, 32'h7777_7777, "R7 map mask reopened");

      reg_wr(3'd4, 8'h02);
      for (int a = 8; a < 12; a++) cpu_write(4'(a), 8'hFF);
      reg_wr(3'd4, 8'h01);
      cpu_write(4'd8, 8'hFF);
      cpu_write(4'd9, 8'hFF);
      cpu_read(4'd8, 32'h0000_FFFF, "R8 blue over green gives cyan");
      cpu_read(4'd10, 32'h0000_FF00, "R8 green untouched");
      reg_wr(3'd4, 8'h0F);
      reg_wr(3'd1, 8'h0F);
      reg_wr(3'd0, 8'h01);
      cpu_write(4'd9, 8'h00);
      cpu_read(4'd9, 32'h0000_00FF, "R8 set/reset gives pure blue");

      repeat (3) @(negedge clk);
      check("R1 all reads answered", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule